// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block turns a two-wire motor command (a speed pulse and a direction level) into four gate enables for a full H-bridge. The bridge has two half bridges, each with one high switch and one low switch. The direction level selects which half bridge is chopped by the speed pulse. The other half bridge keeps its high switch on. While the speed pulse is low, both high switches conduct, so the motor freewheels through the upper pair.

Inside each half bridge, the gate of a switch rises only after the other switch of that half bridge has been off for a programmed number of clock cycles. The two half bridges are timed independently. A disable input removes every gate at the next clock edge. An external permission input, driven by a supervisor, removes every gate in the same cycle, without waiting for a clock edge. For each switch, a single-cycle strobe marks the cycle in which its gate rises, so a downstream fault monitor can start its blanking window there.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With the disable input low, the speed input low and either direction level, the steady state has both high gates on and both low gates off.
- R2: With the disable input low, direction 0 and speed 1, the steady state has half bridge 1 high on and half bridge 2 low on (gate_hs=2'b01, gate_ls=2'b10). Bit 0 is half bridge 1.
- R3: With the disable input low, direction 1 and speed 1, the steady state has half bridge 1 low on and half bridge 2 high on (gate_hs=2'b10, gate_ls=2'b01).
- R4: A high disable input turns all four gates off at the next clock edge, whatever the speed and direction inputs are. After it falls, each gate comes back only through a full dead-time interval.
- R5: A gate rises only after its half bridge has requested that switch at D+2 consecutive clock edges, where D is the dead-time register. The off gap between the two switches of one half bridge is therefore exactly D+1 cycles, and D=0 gives the minimum gap of one cycle.
- R6: After reset the dead-time register holds its maximum value, all ones (4095 for 12 bits).
- R7: If the request for a half bridge changes while its interval is running, the interval restarts from the new request. Neither switch of that half bridge turns on before the restarted interval completes.
- R8: While the permission input is low, all gates are off in the same cycle, with no clock edge needed. After it rises, each gate returns only through a full dead-time interval.
- R9: Each switch has a strobe that is high for exactly one cycle: the first cycle in which that gate is high.
- R10: The high and low gate of one half bridge are never high together.
- R11: A half bridge whose request does not change keeps its gate on without interruption while the other half bridge is switching.
- R12: During reset all gates and strobes are low.
- R13: A write strobe loads the dead-time register at the clock edge. Intervals that start after that edge use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Speed pulse (chops the selected half bridge) |
| dir_in | input | 1 | Direction level (selects the chopped half bridge) |
| drv_off_in | input | 1 | Disable: all gates off at the next edge |
| allow_in | input | 1 | Supervisor permission: low forces all gates off at once |
| dt_wr_en | input | 1 | Write strobe for the dead-time register |
| dt_wr_val | input | DT_W | Dead-time value in clock cycles, minus one |
| gate_hs | output | 2 | High-switch gate enables, bit 0 = half bridge 1 |
| gate_ls | output | 2 | Low-switch gate enables, bit 0 = half bridge 1 |
| on_stb_hs | output | 2 | One-cycle strobe on a rising high gate |
| on_stb_ls | output | 2 | One-cycle strobe on a rising low gate |

## Verification
The bench builds the block with the default 12-bit dead-time register. This lets it run the unprogrammed maximum once, a gap of 4096 cycles, and confirm that the gate rises exactly on the expected edge. All other sweeps reprogram the register to small values (0, 1, 2, 3, 5 and 7). With those values, every ordered pair of the four commands, interrupted intervals, disable pulses and permission drops all fit in a few thousand cycles. Expected gates come from a per-half-bridge count of consecutive edges with an unchanged request, compared against D+2. That arithmetic is independent of the design's down-counter.

// File: rtl/hbgs_pkg.sv
package hbgs_pkg;
  // Which switch of a half bridge is requested or conducting
  typedef enum logic [1:0] {
    SW_NONE = 2'd0,
    SW_HIGH = 2'd1,
    SW_LOW  = 2'd2
  } sw_sel_t;
endpackage

// File: rtl/hbgs_decode.sv
module hbgs_decode
  import hbgs_pkg::*;
(
  input  logic    pwm,
  input  logic    dir,
  input  logic    off,
  output sw_sel_t want_a,
  output sw_sel_t want_b
);
  // Chopped leg is the one selected by dir; the other keeps its high side
  function automatic sw_sel_t leg_request(input logic chop, input logic pulse);
    return (chop && pulse) ? SW_LOW : SW_HIGH;
  endfunction

  always_comb begin
    if (off) begin
      want_a = SW_NONE;
      want_b = SW_NONE;
    end else begin
      want_a = leg_request(dir, pwm);
      want_b = leg_request(!dir, pwm);
    end
  end
endmodule

// File: rtl/hbgs_leg.sv
module hbgs_leg
  import hbgs_pkg::*;
#(
  parameter int DT_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            allow,
  input  sw_sel_t         want,
  input  logic [DT_W-1:0] dt_len,
  output logic            hs_gate,
  output logic            ls_gate,
  output logic            hs_stb,
  output logic            ls_stb
);
  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);
  localparam logic [DT_W:0]   RUN_MAX = '1;

  // Off gap in cycles produced by a register value
  function automatic logic [DT_W+1:0] dead_cycles(input logic [DT_W-1:0] cfg);
    return {2'b00, cfg} + (DT_W+2)'(1);
  endfunction

  sw_sel_t         on_q, on_d, pend_q, pend_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            stb_hs_q, stb_ls_q;
  logic [DT_W:0]   off_run_q;
  logic            turn_on;

  always_comb begin
    on_d   = on_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (!allow) begin
      on_d   = SW_NONE;
      pend_d = SW_NONE;
      cnt_d  = dt_len;
    end else if (on_q != SW_NONE && want == on_q) begin
      on_d = on_q;
    end else if (on_q != SW_NONE) begin
      on_d   = SW_NONE;
      pend_d = want;
      cnt_d  = dt_len;
    end else if (want != pend_q) begin
      pend_d = want;
      cnt_d  = dt_len;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_ONE;
    end else begin
      on_d = want;
    end
  end

  assign turn_on = (on_q == SW_NONE) && (on_d != SW_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q      <= SW_NONE;
      pend_q    <= SW_NONE;
      cnt_q     <= '0;
      stb_hs_q  <= 1'b0;
      stb_ls_q  <= 1'b0;
      off_run_q <= '0;
    end else begin
      on_q     <= on_d;
      pend_q   <= pend_d;
      cnt_q    <= cnt_d;
      stb_hs_q <= turn_on && (on_d == SW_HIGH);
      stb_ls_q <= turn_on && (on_d == SW_LOW);
      if (on_d != SW_NONE)
        off_run_q <= '0;
      else if (on_q == SW_NONE && off_run_q != RUN_MAX)
        off_run_q <= off_run_q + (DT_W+1)'(1);
    end
  end

  assign hs_gate = allow && (on_q == SW_HIGH);
  assign ls_gate = allow && (on_q == SW_LOW);
  assign hs_stb  = allow && stb_hs_q;
  assign ls_stb  = allow && stb_ls_q;

  AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate)); // R10
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q != SW_NONE) |=> (on_q == SW_NONE || $stable(on_q))); // R5
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on && (off_run_q != RUN_MAX) |->
      ({1'b0, off_run_q} + (DT_W+2)'(1) >= dead_cycles(dt_len))); // R5
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> (on_q == SW_NONE)); // R8
  AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && want == SW_NONE) |=> (on_q == SW_NONE)); // R4
  AST_REVERSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q == SW_NONE && want != pend_q) |=> (on_q == SW_NONE)); // R7
  AST_HS_STB_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_stb |-> (hs_gate && !$past(hs_gate))); // R9
  AST_LS_STB_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ls_stb |-> (ls_gate && !$past(ls_gate))); // R9
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbgs_pkg::*;
#(
  parameter int DT_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic            dir_in,
  input  logic            drv_off_in,
  input  logic            allow_in,
  input  logic            dt_wr_en,
  input  logic [DT_W-1:0] dt_wr_val,
  output logic [1:0]      gate_hs,
  output logic [1:0]      gate_ls,
  output logic [1:0]      on_stb_hs,
  output logic [1:0]      on_stb_ls
);
  localparam int NLEG = 2;

  logic [DT_W-1:0] dt_reg;
  sw_sel_t         want [NLEG];
  sw_sel_t         want_a, want_b;

  // Unprogrammed register yields the longest gap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dt_reg <= '1;
    else if (dt_wr_en) dt_reg <= dt_wr_val;
  end

  hbgs_decode u_dec (
    .pwm    (pwm_in),
    .dir    (dir_in),
    .off    (drv_off_in),
    .want_a (want_a),
    .want_b (want_b)
  );

  assign want[0] = want_a;
  assign want[1] = want_b;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hbgs_leg #(.DT_W(DT_W)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .allow   (allow_in),
      .want    (want[g]),
      .dt_len  (dt_reg),
      .hs_gate (gate_hs[g]),
      .ls_gate (gate_ls[g]),
      .hs_stb  (on_stb_hs[g]),
      .ls_stb  (on_stb_ls[g])
    );
  end

  AST_DT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dt_wr_en |=> (dt_reg == $past(dt_wr_val))); // R13
  AST_ALLOW_LOW_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !allow_in |-> (gate_hs == 2'b00 && gate_ls == 2'b00)); // R8
endmodule

// File: tb/sim_hbridge_gate_seq.sv
module sim_hbridge_gate_seq;
  localparam int DT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_i = 1'b0, dir_i = 1'b0, dis_i = 1'b0, allow_i = 1'b0;
  logic dt_wr_en = 1'b0;
  logic [DT_W-1:0] dt_wr_val = '0;
  logic [1:0] g_hs, g_ls, s_hs, s_ls;

  int checks = 0;
  int errors = 0;
  int dt_m = 4095;
  int run [2];
  int prv [2];
  logic pv_hs [2];
  logic pv_ls [2];
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  hbridge_gate_seq #(.DT_W(DT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_i), .dir_in(dir_i),
    .drv_off_in(dis_i), .allow_in(allow_i), .dt_wr_en(dt_wr_en),
    .dt_wr_val(dt_wr_val), .gate_hs(g_hs), .gate_ls(g_ls),
    .on_stb_hs(s_hs), .on_stb_ls(s_ls)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, got, exp);
    end
  endtask

  // Request per leg: 0 none, 1 high, 2 low
  function automatic int req(input int leg, input logic p, input logic d, input logic s);
    if (s) return 0;
    if (leg == 0) return (d && p) ? 2 : 1;
    return (!d && p) ? 2 : 1;
  endfunction

  function automatic string cmd_tag(input logic p, input logic d);
    if (!p) return "R1";
    return d ? "R3" : "R2";
  endfunction

  task automatic cyc(input logic p, input logic d, input logic s, input logic a, input string tag);
    string t;
    logic eh, el;
    pwm_i = p; dir_i = d; dis_i = s; allow_i = a;
    @(posedge clk);
    for (int l = 0; l < 2; l++) begin
      int r;
      r = req(l, p, d, s);
      if (!a) begin run[l] = 0; prv[l] = 3; end
      else if (r == prv[l]) begin if (run[l] < 100000) run[l]++; end
      else begin run[l] = 1; prv[l] = r; end
    end
    if (dt_wr_en) dt_m = int'(dt_wr_val);
    @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      t = tag;
      if (tag == "AUTO")
        t = (a && !s && run[l] < dt_m + 2) ? "R5" : cmd_tag(p, d);
      eh = a && prv[l] == 1 && run[l] >= dt_m + 2;
      el = a && prv[l] == 2 && run[l] >= dt_m + 2;
      chk(t, $sformatf("gate_hs[%0d]", l), g_hs[l], eh);
      chk(t, $sformatf("gate_ls[%0d]", l), g_ls[l], el);
      chk("R9", $sformatf("on_stb_hs[%0d]", l), s_hs[l], eh && !pv_hs[l]);
      chk("R9", $sformatf("on_stb_ls[%0d]", l), s_ls[l], el && !pv_ls[l]);
      chk("R10", $sformatf("leg %0d both on", l), g_hs[l] && g_ls[l], 1'b0);
      pv_hs[l] = eh;
      pv_ls[l] = el;
    end
  endtask

  task automatic set_dt(input int v);
    dt_wr_en = 1'b1;
    dt_wr_val = DT_W'(v);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R13");
    dt_wr_en = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R8");
  endtask

  function automatic logic [15:0] lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dts [5];
    for (int l = 0; l < 2; l++) begin run[l] = 0; prv[l] = 3; pv_hs[l] = 0; pv_ls[l] = 0; end
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "gate_hs", |g_hs, 1'b0);
    chk("R12", "gate_ls", |g_ls, 1'b0);
    chk("R12", "on_stb_hs", |s_hs, 1'b0);
    chk("R12", "on_stb_ls", |s_ls, 1'b0);
    rst_n = 1'b1;

    // R6: unprogrammed register gives 4096-cycle gap
    for (int i = 0; i < 4100; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, "R6");

    // R1/R2/R3/R5: all ordered command pairs for several dead times
    dts = '{0, 1, 2, 3, 7};
    foreach (dts[k]) begin
      set_dt(dts[k]);
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          for (int i = 0; i < dts[k] + 4; i++) cyc(a[0], a[1], 1'b0, 1'b1, "AUTO");
          for (int i = 0; i < dts[k] + 4; i++) cyc(b[0], b[1], 1'b0, 1'b1, "AUTO");
        end
    end

    // R11: dir=0 chopping leg 2, leg 1 high side must stay on
    set_dt(3);
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, "R11");
    for (int n = 0; n < 6; n++)
      for (int i = 0; i < 7; i++) begin
        cyc(n[0], 1'b0, 1'b0, 1'b1, "R11");
        chk("R11", "leg 1 high held", g_hs[0], 1'b1);
      end

    // R7: short dwells that interrupt running intervals
    set_dt(5);
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, "R7");
    for (int n = 0; n < 150; n++) begin
      int dwell;
      lf = lfsr(lf);
      dwell = 1 + int'(lf[2:0]);
      for (int i = 0; i < dwell; i++) cyc(lf[8], lf[9], 1'b0, 1'b1, "R7");
    end

    // R4: disable pulses
    set_dt(2);
    for (int n = 0; n < 40; n++) begin
      lf = lfsr(lf);
      for (int i = 0; i < 6; i++) cyc(lf[4], lf[5], 1'b0, 1'b1, "R4");
      for (int i = 0; i <= int'(lf[1:0]); i++) cyc(lf[6], lf[7], 1'b1, 1'b1, "R4");
    end

    // R8: permission drops, including the same-cycle removal
    for (int n = 0; n < 40; n++) begin
      lf = lfsr(lf);
      for (int i = 0; i < 7; i++) cyc(lf[4], lf[5], 1'b0, 1'b1, "R8");
      allow_i = 1'b0;
      #1;
      chk("R8", "gates before edge", |{g_hs, g_ls}, 1'b0);
      for (int i = 0; i <= int'(lf[1:0]); i++) cyc(lf[6], lf[7], 1'b0, 1'b0, "R8");
    end
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule